// File: doc/BRIEF.md
# Backplane Slave Port with Register Window

This block lets a home-built readout card answer single read and write cycles on an asynchronous, strobe-handshaked backplane. It watches the active-low address strobe, the two data strobes and the direction and width qualifiers. It checks the six-bit address-modifier code and the address against a configured window. When a cycle is meant for this card, it completes the transfer against a small bank of 32-bit registers. It then acknowledges by pulling the acknowledge line low.

The acknowledge is not a fixed-latency pulse. It stays asserted until the master has withdrawn every strobe, and only then is it released. Cycles that carry a foreign modifier code or an address outside the window get no response at all, so the crate controller's timeout reports the error. Every backplane input arrives as raw samples and is passed through a synchronizer chain before any decision is made. Local logic sees one-clock read and write strobes carrying the register index, byte enables and write data. A board-select output stays high for the whole life of a claimed cycle.

Top module: `vme_slave_port`

## Requirements
- R1: After reset the acknowledge output is high (released), the data-enable output is low, board select is low, both local strobes are low, and every register reads back as 0.
- R2: A cycle with modifier code 0x09 is claimed when address bits 31 down to WIN_LSB equal the configured 32-bit base, where WIN_LSB = log2(NREGS)+2. The register index is taken from address bits WIN_LSB-1 down to 2.
- R3: When the 24-bit option is enabled, a cycle with modifier code 0x39 is claimed when address bits 23 down to WIN_LSB equal the 24-bit base. Address bits 31 to 24 play no part in that match.
- R4: A cycle with any other modifier code, or with an address outside the window, is ignored. The acknowledge is never asserted, board select stays low, no local strobe fires, and no register changes.
- R5: The acknowledge goes low only while the address strobe and at least one data strobe are low. It goes low no earlier than three local clocks after the data strobe first reaches the input pins. The address strobe alone never produces an acknowledge.
- R6: Once low, the acknowledge stays low for as long as the address strobe or either data strobe remains low. It returns high only after all three have been seen high, and no new cycle is accepted before that.
- R7: On a read, the data-enable output is high at least one clock before the acknowledge goes low. It drops in the same clock that the acknowledge is released.
- R8: Byte enables: with the long-word qualifier low, all four bytes are written. With it high, address bit 1 picks the half: 1 selects bits 15:0 and 0 selects bits 31:16. Within that half, data strobe 1 enables the upper byte and data strobe 0 the lower byte. Data sits on the data lines at the byte's own position, and a read always returns the whole register.
- R9: Board select is high from the clock a cycle is claimed until the clock the acknowledge is released.
- R10: Each claimed write cycle produces exactly one write-strobe clock, and each claimed read cycle exactly one read-strobe clock. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vme_as_n | input | 1 | Address strobe sample, active low |
| vme_ds0_n | input | 1 | Data strobe 0 sample, active low |
| vme_ds1_n | input | 1 | Data strobe 1 sample, active low |
| vme_write_n | input | 1 | Direction, low means write |
| vme_lword_n | input | 1 | Long-word qualifier, active low |
| vme_addr | input | 31 | Address lines 31 to 1 |
| vme_am | input | 6 | Address-modifier code |
| vme_data_in | input | 32 | Data lines as seen from the backplane |
| vme_data_out | output | 32 | Read data to drive onto the data lines |
| vme_data_oe | output | 1 | Enable for the data-line drivers |
| vme_dtack_n | output | 1 | Acknowledge, active low |
| board_sel | output | 1 | Cycle-addresses-this-card indicator |
| loc_wr_stb | output | 1 | One-clock register write strobe |
| loc_rd_stb | output | 1 | One-clock register read strobe |
| loc_idx | output | IDXW | Register index of the current cycle |
| loc_be | output | 4 | Byte enables of the current cycle |
| loc_wdata | output | 32 | Latched write data of the current cycle |

## Verification
The bench holds the data strobes low for thirty clocks after the acknowledge arrives. A design that used a fixed-length acknowledge pulse would release early and fail there. It sends cycles with a foreign modifier code, with an address one window away, and with the address strobe alone. It then reads the target register back, so a decoder that ignored the modifier code, or a port that answered without a data strobe, would show up as a spurious acknowledge or a changed register. Sixteen-bit and single-byte writes land in both halves, which catches a swapped half-select or a swapped strobe-to-byte mapping. The drive enable is sampled one clock before the acknowledge and at its release, which exposes data that is late or left driven after the cycle.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

   localparam logic [5:0] AM_A32_DATA = 6'h09;
   localparam logic [5:0] AM_A24_DATA = 6'h39;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LATCH,
      ST_DRIVE,
      ST_ACK,
      ST_SKIP
   } cyc_state_t;

   // byte enables, bit 3 = data bits 31:24
   function automatic logic [3:0] lane_mask(input logic lword_n, input logic a1,
                                            input logic ds1_n, input logic ds0_n);
      logic [1:0] pair;
      pair = {~ds1_n, ~ds0_n};
      if (!lword_n)
         return 4'hF;
      else if (a1)
         return {2'b00, pair};
      else
         return {pair, 2'b00};
   endfunction

endpackage

// File: rtl/vsp_sync.sv
module vsp_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $error("vsp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= RST_VAL;
            else        stg_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= RST_VAL;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/vsp_decode.sv
module vsp_decode
   import vsp_pkg::*;
#(
   parameter int unsigned WIN_LSB    = 5,
   parameter logic [31:0] BASE_A32   = 32'h0012_3400,
   parameter bit          ACCEPT_A24 = 1'b1,
   parameter logic [23:0] BASE_A24   = 24'h00_8000
) (
   input  logic [31:1] addr,
   input  logic [5:0]  am,
   output logic        hit
);

   initial begin
      assert (WIN_LSB >= 3 && WIN_LSB <= 23) else $error("vsp_decode: window width out of range");
   end

   logic hit32;
   logic hit24;

   assign hit32 = (am == AM_A32_DATA) && (addr[31:WIN_LSB] == BASE_A32[31:WIN_LSB]);

   if (ACCEPT_A24) begin : g_a24
      assign hit24 = (am == AM_A24_DATA) && (addr[23:WIN_LSB] == BASE_A24[23:WIN_LSB]);
   end else begin : g_no_a24
      assign hit24 = 1'b0;
   end

   assign hit = hit32 | hit24;

endmodule

// File: rtl/vsp_regfile.sv
module vsp_regfile #(
   parameter int unsigned NREGS = 8,
   parameter int unsigned IDXW  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic [3:0]      wr_be,
   input  logic [31:0]     wr_data,
   input  logic [IDXW-1:0] rd_idx,
   output logic [31:0]     rd_data
);

   initial begin
      assert (NREGS == (1 << IDXW)) else $error("vsp_regfile: NREGS must equal 2**IDXW");
   end

   logic [NREGS-1:0][31:0] flat;

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_idx == IDXW'(g))) begin
            for (int b = 0; b < 4; b++)
               if (wr_be[b]) q[8*b +: 8] <= wr_data[8*b +: 8];
         end
      end
      assign flat[g] = q;
   end

   assign rd_data = flat[rd_idx];

endmodule

// File: rtl/vme_slave_port.sv
module vme_slave_port
   import vsp_pkg::*;
#(
   parameter int unsigned NREGS       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [31:0] BASE_A32    = 32'h0012_3400,
   parameter bit          ACCEPT_A24  = 1'b1,
   parameter logic [23:0] BASE_A24    = 24'h00_8000,
   localparam int unsigned IDXW       = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vme_as_n,
   input  logic            vme_ds0_n,
   input  logic            vme_ds1_n,
   input  logic            vme_write_n,
   input  logic            vme_lword_n,
   input  logic [31:1]     vme_addr,
   input  logic [5:0]      vme_am,
   input  logic [31:0]     vme_data_in,
   output logic [31:0]     vme_data_out,
   output logic            vme_data_oe,
   output logic            vme_dtack_n,
   output logic            board_sel,
   output logic            loc_wr_stb,
   output logic            loc_rd_stb,
   output logic [IDXW-1:0] loc_idx,
   output logic [3:0]      loc_be,
   output logic [31:0]     loc_wdata
);

   localparam int unsigned WIN_LSB = IDXW + 2;
   localparam int unsigned SYNC_W  = 5 + 6 + 31 + 32;
   localparam logic [SYNC_W-1:0] SYNC_RST = {5'b11111, {(SYNC_W-5){1'b0}}};

   initial begin
      assert (NREGS >= 2) else $error("vme_slave_port: need at least two registers");
      assert (BASE_A32[WIN_LSB-1:0] == '0) else $error("vme_slave_port: 32-bit base not window aligned");
      assert (BASE_A24[WIN_LSB-1:0] == '0) else $error("vme_slave_port: 24-bit base not window aligned");
   end

   // ---------------- input synchronization ----------------
   logic [SYNC_W-1:0] raw_v, smp_v;
   logic        as_s, ds0_s, ds1_s, wr_s, lw_s;
   logic [5:0]  am_s;
   logic [31:1] addr_s;
   logic [31:0] data_s;

   assign raw_v = {vme_as_n, vme_ds0_n, vme_ds1_n, vme_write_n, vme_lword_n,
                   vme_am, vme_addr, vme_data_in};

   vsp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_v),
      .q     (smp_v)
   );

   assign {as_s, ds0_s, ds1_s, wr_s, lw_s, am_s, addr_s, data_s} = smp_v;

   // ---------------- address / modifier decode ----------------
   logic hit;

   vsp_decode #(
      .WIN_LSB    (WIN_LSB),
      .BASE_A32   (BASE_A32),
      .ACCEPT_A24 (ACCEPT_A24),
      .BASE_A24   (BASE_A24)
   ) decode_i (
      .addr (addr_s),
      .am   (am_s),
      .hit  (hit)
   );

   // ---------------- cycle controller ----------------
   cyc_state_t  state_q;
   logic        cyc_wr_q;
   logic [IDXW-1:0] cyc_idx_q;
   logic [3:0]  cyc_be_q;
   logic [31:0] cyc_wdata_q;
   logic [31:0] dout_q;
   logic        oe_q;
   logic        dtack_n_q;
   logic        sel_q;
   logic [31:0] rf_rdata;

   logic strobe_on;
   logic all_released;

   assign strobe_on    = !as_s && (!ds0_s || !ds1_s);
   assign all_released = as_s && ds0_s && ds1_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cyc_wr_q    <= 1'b0;
         cyc_idx_q   <= '0;
         cyc_be_q    <= '0;
         cyc_wdata_q <= '0;
         dout_q      <= '0;
         oe_q        <= 1'b0;
         dtack_n_q   <= 1'b1;
         sel_q       <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (strobe_on) begin
                  if (hit) begin
                     state_q     <= ST_LATCH;
                     sel_q       <= 1'b1;
                     cyc_wr_q    <= !wr_s;
                     cyc_idx_q   <= addr_s[WIN_LSB-1:2];
                     cyc_be_q    <= lane_mask(lw_s, addr_s[1], ds1_s, ds0_s);
                     cyc_wdata_q <= data_s;
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
            end
            ST_LATCH: begin
               state_q <= ST_DRIVE;
               if (!cyc_wr_q) begin
                  dout_q <= rf_rdata;
                  oe_q   <= 1'b1;
               end
            end
            ST_DRIVE: begin
               state_q   <= ST_ACK;
               dtack_n_q <= 1'b0;
            end
            ST_ACK: begin
               if (all_released) begin
                  state_q   <= ST_IDLE;
                  dtack_n_q <= 1'b1;
                  oe_q      <= 1'b0;
                  sel_q     <= 1'b0;
               end
            end
            ST_SKIP: begin
               if (all_released) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign loc_wr_stb   = (state_q == ST_LATCH) &&  cyc_wr_q;
   assign loc_rd_stb   = (state_q == ST_LATCH) && !cyc_wr_q;
   assign loc_idx      = cyc_idx_q;
   assign loc_be       = cyc_be_q;
   assign loc_wdata    = cyc_wdata_q;
   assign vme_data_out = dout_q;
   assign vme_data_oe  = oe_q;
   assign vme_dtack_n  = dtack_n_q;
   assign board_sel    = sel_q;

   // ---------------- register bank ----------------
   vsp_regfile #(.NREGS(NREGS), .IDXW(IDXW)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (loc_wr_stb),
      .wr_idx  (cyc_idx_q),
      .wr_be   (cyc_be_q),
      .wr_data (cyc_wdata_q),
      .rd_idx  (cyc_idx_q),
      .rd_data (rf_rdata)
   );

   // ---------------- assertions ----------------
   a_r5_dtack_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vme_dtack_n) |-> $past(!as_s && (!ds0_s || !ds1_s)));

   a_r9_dtack_implies_select: assert property (@(posedge clk) disable iff (!rst_n)
      !vme_dtack_n |-> board_sel);

   a_r6_hold_while_strobed: assert property (@(posedge clk) disable iff (!rst_n)
      (!vme_dtack_n && !all_released) |=> !vme_dtack_n);

   a_r6_release_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      (!vme_dtack_n && all_released) |=> vme_dtack_n);

   a_r7_oe_drops_with_dtack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vme_dtack_n) |-> !vme_data_oe);

   a_r7_data_before_dtack: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(vme_dtack_n) && vme_data_oe) |-> $past(vme_data_oe));

   a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_wr_stb && loc_rd_stb));

   a_r10_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_wr_stb || loc_rd_stb) |=> !(loc_wr_stb || loc_rd_stb));

   a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> (vme_dtack_n && !board_sel && !loc_wr_stb && !loc_rd_stb));

endmodule

// File: tb/vme_slave_port_tb_top.sv
module vme_slave_port_tb_top;

   localparam logic [31:0] BASE32 = 32'h0012_3400;
   localparam logic [23:0] BASE24 = 24'h00_8000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, write_n = 1'b1, lword_n = 1'b1;
   logic [31:1] addr = '0;
   logic [5:0]  am = '0;
   logic [31:0] data_in = '0;
   logic [31:0] data_out;
   logic        data_oe, dtack_n, board_sel, loc_wr_stb, loc_rd_stb;
   logic [2:0]  loc_idx;
   logic [3:0]  loc_be;
   logic [31:0] loc_wdata;

   vme_slave_port #(.NREGS(8), .BASE_A32(BASE32), .ACCEPT_A24(1'b1), .BASE_A24(BASE24)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .vme_as_n(as_n), .vme_ds0_n(ds0_n), .vme_ds1_n(ds1_n),
      .vme_write_n(write_n), .vme_lword_n(lword_n),
      .vme_addr(addr), .vme_am(am), .vme_data_in(data_in),
      .vme_data_out(data_out), .vme_data_oe(data_oe), .vme_dtack_n(dtack_n),
      .board_sel(board_sel), .loc_wr_stb(loc_wr_stb), .loc_rd_stb(loc_rd_stb),
      .loc_idx(loc_idx), .loc_be(loc_be), .loc_wdata(loc_wdata)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // results of the last cycle
   bit          r_ack, r_sel, r_oe_first, r_held, r_rel;
   logic [31:0] r_data;
   int          r_lat, r_wr, r_rd;
   logic [2:0]  r_idx;

   task automatic vme_cycle(input logic [31:0] a, input logic [5:0] m, input bit wr,
                            input bit lw32, input bit s1, input bit s0,
                            input logic [31:0] wd, input int hold);
      bit prev_oe;
      @(negedge clk);
      addr = a[31:1]; am = m; write_n = !wr; lword_n = !lw32;
      @(negedge clk);
      as_n = 1'b0; data_in = wd;
      @(negedge clk);
      ds1_n = !s1; ds0_n = !s0;
      r_ack = 0; r_sel = 0; r_oe_first = 0; r_held = 1; r_rel = 0;
      r_lat = 0; r_wr = 0; r_rd = 0; r_data = '0; r_idx = '0; prev_oe = 0;
      for (int i = 0; i < 30 && !r_ack; i++) begin
         @(negedge clk);
         r_lat++;
         if (loc_wr_stb) begin r_wr++; r_idx = loc_idx; end
         if (loc_rd_stb) begin r_rd++; r_idx = loc_idx; end
         if (board_sel) r_sel = 1;
         if (!dtack_n) begin
            r_ack = 1; r_data = data_out; r_oe_first = prev_oe && data_oe;
         end
         prev_oe = data_oe;
      end
      if (r_ack) begin
         for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (dtack_n || !board_sel) r_held = 0;
            if (loc_wr_stb) r_wr++;
            if (loc_rd_stb) r_rd++;
         end
      end
      as_n = 1'b1; ds0_n = 1'b1; ds1_n = 1'b1; write_n = 1'b1; lword_n = 1'b1;
      if (r_ack) begin
         for (int i = 0; i < 10 && !r_rel; i++) begin
            @(negedge clk);
            if (dtack_n) r_rel = !data_oe && !board_sel;
            if (dtack_n && data_oe) i = 10;
         end
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic write32(input logic [31:0] a, input logic [31:0] d);
      vme_cycle(a, 6'h09, 1'b1, 1'b1, 1'b1, 1'b1, d, 0);
   endtask

   task automatic read32(input logic [31:0] a, output logic [31:0] d);
      vme_cycle(a, 6'h09, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0, 0);
      d = r_data;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk(dtack_n == 1'b1, "R1 dtack after reset", {31'd0, dtack_n}, 32'd1);
      chk(data_oe == 1'b0 && board_sel == 1'b0, "R1 oe/select after reset", {30'd0, data_oe, board_sel}, 32'd0);
      chk(!loc_wr_stb && !loc_rd_stb, "R1 strobes after reset", {30'd0, loc_wr_stb, loc_rd_stb}, 32'd0);
      read32(BASE32 + 32'h1C, d);
      chk(r_ack && d == 32'h0, "R1 register reset value", d, 32'h0);
   endtask

   task automatic t_word_rw;
      logic [31:0] d;
      write32(BASE32 + 32'h08, 32'hDEAD_BEEF);
      chk(r_ack, "R2 write claimed", {31'd0, r_ack}, 32'd1);
      chk(r_wr == 1 && r_rd == 0, "R10 one write strobe", r_wr, 32'd1);
      chk(r_idx == 3'd2, "R2 write index", {29'd0, r_idx}, 32'd2);
      chk(r_sel && r_rel, "R9 select during and after write", {30'd0, r_sel, r_rel}, 32'd3);
      chk(r_lat >= 3, "R5 acknowledge latency", r_lat, 32'd3);
      read32(BASE32 + 32'h08, d);
      chk(d == 32'hDEAD_BEEF, "R2 read back", d, 32'hDEAD_BEEF);
      chk(r_rd == 1 && r_wr == 0, "R10 one read strobe", r_rd, 32'd1);
      chk(r_oe_first, "R7 data driven before acknowledge", {31'd0, r_oe_first}, 32'd1);
      chk(r_rel, "R7 drive enable dropped with release", {31'd0, r_rel}, 32'd1);
   endtask

   task automatic t_hold;
      vme_cycle(BASE32 + 32'h08, 6'h09, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0, 30);
      chk(r_ack && r_held, "R6 acknowledge held while strobes low", {31'd0, r_held}, 32'd1);
      chk(r_rel, "R6 acknowledge released after strobes", {31'd0, r_rel}, 32'd1);
      chk(r_rd == 1, "R10 single read strobe across long hold", r_rd, 32'd1);
   endtask

   task automatic t_lanes;
      logic [31:0] d;
      write32(BASE32 + 32'h04, 32'h1122_3344);
      // 16-bit, A1=1, both strobes: bits 15:0
      vme_cycle(BASE32 + 32'h06, 6'h09, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_AABB, 0);
      read32(BASE32 + 32'h04, d);
      chk(d == 32'h1122_AABB, "R8 lower half write", d, 32'h1122_AABB);
      // A1=0, strobe 1 only: bits 31:24
      vme_cycle(BASE32 + 32'h04, 6'h09, 1'b1, 1'b0, 1'b1, 1'b0, 32'hCC00_0000, 0);
      read32(BASE32 + 32'h04, d);
      chk(d == 32'hCC22_AABB, "R8 upper byte of upper half", d, 32'hCC22_AABB);
      // A1=1, strobe 0 only: bits 7:0
      vme_cycle(BASE32 + 32'h06, 6'h09, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_00EE, 0);
      read32(BASE32 + 32'h04, d);
      chk(d == 32'hCC22_AAEE, "R8 lower byte of lower half", d, 32'hCC22_AAEE);
   endtask

   task automatic t_am_miss;
      logic [31:0] d;
      write32(BASE32 + 32'h0C, 32'h5555_0000);
      vme_cycle(BASE32 + 32'h0C, 6'h3D, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 0);
      chk(!r_ack && !r_sel, "R4 foreign modifier not acknowledged", {30'd0, r_ack, r_sel}, 32'd0);
      chk(r_wr == 0 && r_rd == 0, "R4 foreign modifier no strobe", r_wr + r_rd, 32'd0);
      read32(BASE32 + 32'h0C, d);
      chk(d == 32'h5555_0000, "R4 register untouched by foreign modifier", d, 32'h5555_0000);
   endtask

   task automatic t_addr_miss;
      logic [31:0] d;
      vme_cycle(BASE32 + 32'h2C, 6'h09, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 0);
      chk(!r_ack && !r_sel, "R4 next window not acknowledged", {30'd0, r_ack, r_sel}, 32'd0);
      vme_cycle(BASE32 ^ 32'h8000_000C, 6'h09, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 0);
      chk(!r_ack && r_wr == 0, "R4 high address bit mismatch ignored", {31'd0, r_ack}, 32'd0);
      read32(BASE32 + 32'h0C, d);
      chk(d == 32'h5555_0000, "R4 register untouched by address miss", d, 32'h5555_0000);
   endtask

   task automatic t_a24;
      logic [31:0] d;
      vme_cycle({8'hA5, BASE24 + 24'h0C}, 6'h39, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0A24_0A24, 0);
      chk(r_ack && r_idx == 3'd3, "R3 24-bit cycle claimed", {29'd0, r_idx}, 32'd3);
      read32(BASE32 + 32'h0C, d);
      chk(d == 32'h0A24_0A24, "R3 24-bit write landed", d, 32'h0A24_0A24);
      vme_cycle({8'h00, BASE24 + 24'h0C}, 6'h09, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0, 0);
      chk(!r_ack, "R3 24-bit base with 32-bit modifier ignored", {31'd0, r_ack}, 32'd0);
   endtask

   task automatic t_as_only;
      bit seen;
      seen = 0;
      @(negedge clk);
      addr = (BASE32 + 32'h08) >> 1; am = 6'h09; write_n = 1'b0; lword_n = 1'b0;
      @(negedge clk);
      as_n = 1'b0;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (!dtack_n || board_sel) seen = 1;
      end
      as_n = 1'b1; write_n = 1'b1; lword_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!seen, "R5 address strobe alone gives no acknowledge", {31'd0, seen}, 32'd0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_word_rw();
      t_hold();
      t_lanes();
      t_am_miss();
      t_addr_miss();
      t_a24();
      t_as_only();
      finish_run();
   end

endmodule